// File: doc/BRIEF.md
# Status Flag and Bit Transfer Unit

This block holds the processor status byte and carries out the single-bit instructions that work on it. A generic set or a generic clear writes one flag, which a 3-bit index selects. Every named flag instruction (carry, zero, negative, overflow, sign, half-carry, transfer bit, interrupt enable) is this generic operation with a fixed index. The transfer flag T links register bits and the status byte. One operation copies a chosen bit of a register operand into T. Another writes T into a chosen bit of a register operand and passes the result out.

The block also owns a small bank of I/O registers, 32 locations at the default size. It sets or clears single bits in them with a read-modify-write that takes two clocks. During the second clock the block reports busy and ignores new operations. At the end of that clock it presents the written address and data on a one-cycle write strobe. Flags produced by arithmetic are not part of this block.

Top module: `flagbit_unit`

## Requirements
- R1: After reset, `sreg_out`, `reg_out`, `io_wr_en`, `io_wr_addr`, `io_wr_data` and `busy` are all zero, and every I/O location holds 0x00.
- R2: Opcode 1 (flag set) with `op_valid` high and `busy` low makes `sreg_out[bit_idx]` 1 after the next clock edge and leaves the other seven flags unchanged. The bit order from MSB to LSB is I, T, H, S, V, N, Z, C, so index 7 turns on the global interrupt enable and index 0 sets carry.
- R3: Opcode 2 (flag clear) makes `sreg_out[bit_idx]` 0 after the next clock edge and leaves the other flags unchanged. Index 7 turns off the global interrupt enable.
- R4: Opcode 3 (bit store) copies `reg_in[bit_idx]` into T (`sreg_out[6]`) in one clock and leaves the other flags unchanged.
- R5: Opcode 4 (bit load) makes `reg_out` equal to `reg_in` with bit `bit_idx` replaced by T, one clock after the operation. `reg_out` holds its value under every other opcode.
- R6: Opcodes 5 (I/O bit set) and 6 (I/O bit clear) act on location `io_addr` (5 bits). After the first edge `busy` is 1. After the second edge `busy` is 0 and `io_wr_en` is 1 for exactly one cycle. At that point `io_wr_addr` is the address and `io_wr_data` is the old contents of the location with bit `bit_idx` forced to 1 or 0. The location keeps that value for later operations.
- R7: I/O bit operations never change `sreg_out`. Any operation presented while `busy` is 1 is ignored.
- R8: Opcodes 0 and 7, and any cycle with `op_valid` low, change neither the status byte, `reg_out` nor the I/O bank, and raise no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select |
| bit_idx | input | 3 | Flag index or register/I/O bit index |
| reg_in | input | 8 | Register operand |
| io_addr | input | 5 | I/O location for bit operations |
| sreg_out | output | 8 | Status byte {I,T,H,S,V,N,Z,C} |
| reg_out | output | 8 | Register result of the bit-load operation |
| busy | output | 1 | Second cycle of an I/O bit operation |
| io_wr_en | output | 1 | One-cycle I/O write strobe |
| io_wr_addr | output | 5 | Address of the I/O write |
| io_wr_data | output | 8 | Data of the I/O write |

## Verification
The hardest situation to reach is an operation arriving during the busy cycle of an I/O bit operation. It must leave no trace: no flag change, no `reg_out` change and no second write. The bench drives a random valid operation into every busy cycle. It then checks the status byte and `reg_out` against a model that ignores that operation. Read-modify-write accumulation is the other hard case, because the bank can only be seen through the write strobe. The random I/O addresses are therefore narrowed to a few locations, so that repeated sets and clears build up known patterns, and each strobe's data reflects every earlier change.

// File: rtl/flagbit_unit.sv
module flagbit_unit #(
  parameter int IO_AW = 5,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [2:0]       bit_idx,
  input  logic [DW-1:0]    reg_in,
  input  logic [IO_AW-1:0] io_addr,
  output logic [7:0]       sreg_out,
  output logic [DW-1:0]    reg_out,
  output logic             busy,
  output logic             io_wr_en,
  output logic [IO_AW-1:0] io_wr_addr,
  output logic [DW-1:0]    io_wr_data
);
  localparam int IO_DEPTH = 1 << IO_AW;
  localparam int T_POS    = 6;

  localparam logic [2:0] OP_FSET = 3'd1;
  localparam logic [2:0] OP_FCLR = 3'd2;
  localparam logic [2:0] OP_TST  = 3'd3;
  localparam logic [2:0] OP_TLD  = 3'd4;
  localparam logic [2:0] OP_IOS  = 3'd5;
  localparam logic [2:0] OP_IOC  = 3'd6;

  logic [DW-1:0]    bank [IO_DEPTH];
  logic [IO_AW-1:0] pend_addr;
  logic [2:0]       pend_bit;
  logic             pend_set;
  logic [DW-1:0]    old_val, new_val;
  logic             go;

  assign go      = op_valid && !busy;
  assign old_val = bank[pend_addr];

  always_comb begin
    new_val = old_val;
    new_val[pend_bit] = pend_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_out <= '0;
      reg_out  <= '0;
    end else if (go) begin
      case (op_code)
        OP_FSET: sreg_out[bit_idx] <= 1'b1;
        OP_FCLR: sreg_out[bit_idx] <= 1'b0;
        OP_TST:  sreg_out[T_POS]   <= reg_in[bit_idx];
        OP_TLD: begin
          reg_out          <= reg_in;
          reg_out[bit_idx] <= sreg_out[T_POS];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend_addr  <= '0;
      pend_bit   <= '0;
      pend_set   <= 1'b0;
      io_wr_en   <= 1'b0;
      io_wr_addr <= '0;
      io_wr_data <= '0;
    end else begin
      io_wr_en <= 1'b0;
      if (busy) begin
        busy       <= 1'b0;
        io_wr_en   <= 1'b1;
        io_wr_addr <= pend_addr;
        io_wr_data <= new_val;
      end else if (go && (op_code == OP_IOS || op_code == OP_IOC)) begin
        busy      <= 1'b1;
        pend_addr <= io_addr;
        pend_bit  <= bit_idx;
        pend_set  <= (op_code == OP_IOS);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IO_DEPTH; i++) bank[i] <= '0;
    end else if (busy) begin
      bank[pend_addr] <= new_val;
    end
  end
endmodule

module flagbit_unit_chk #(
  parameter int IO_AW = 5,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic [2:0]       bit_idx,
  input logic [7:0]       sreg_out,
  input logic [DW-1:0]    reg_out,
  input logic             busy,
  input logic             io_wr_en
);
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == 3'd1) |=> sreg_out[$past(bit_idx)]);
  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == 3'd2) |=> !sreg_out[$past(bit_idx)]);
  assert_single_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(sreg_out ^ $past(sreg_out)) <= 1));
  assert_reg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && !busy && op_code == 3'd4) |=> $stable(reg_out));
  assert_busy_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && io_wr_en));
  assert_strobe_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_wr_en) |-> $past(busy));
  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sreg_out));
  assert_nop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!op_valid || op_code == 3'd0 || op_code == 3'd7)) |=> ($stable(sreg_out) && !busy && !io_wr_en));
endmodule

bind flagbit_unit flagbit_unit_chk #(.IO_AW(IO_AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .bit_idx(bit_idx), .sreg_out(sreg_out), .reg_out(reg_out),
  .busy(busy), .io_wr_en(io_wr_en)
);

// File: tb/sim_flagbit_unit.sv
module sim_flagbit_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] reg_in = '0;
  logic [4:0] io_addr = '0;
  logic [7:0] sreg_out, reg_out, io_wr_data;
  logic [4:0] io_wr_addr;
  logic       busy, io_wr_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_sreg = '0;
  logic [7:0] m_reg  = '0;
  logic [7:0] m_bank [32];

  always #10 clk = ~clk;

  flagbit_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] put_bit(input logic [7:0] v, input logic [2:0] b, input logic x);
    logic [7:0] r;
    r = v;
    r[b] = x;
    return r;
  endfunction

  task automatic do_op(input logic [2:0] code, input logic [2:0] b,
                       input logic [7:0] rv, input logic [4:0] a);
    string tag;
    logic [7:0] nv;
    @(negedge clk);
    op_valid = 1'b1; op_code = code; bit_idx = b; reg_in = rv; io_addr = a;
    @(posedge clk); #1;
    case (code)
      3'd1: begin m_sreg[b] = 1'b1; tag = "R2"; end
      3'd2: begin m_sreg[b] = 1'b0; tag = "R3"; end
      3'd3: begin m_sreg[6] = rv[b]; tag = "R4"; end
      3'd4: begin m_reg = put_bit(rv, b, m_sreg[6]); tag = "R5"; end
      3'd5, 3'd6: tag = "R6";
      default: tag = "R8";
    endcase
    if (code == 3'd5 || code == 3'd6) begin
      chk("R6 busy after first edge", busy, 1);
      chk("R6 no strobe in first cycle", io_wr_en, 0);
      @(negedge clk);
      op_valid = 1'b1; op_code = 3'($urandom_range(1, 6));
      bit_idx = 3'($urandom); reg_in = 8'($urandom); io_addr = 5'($urandom);
      @(posedge clk); #1;
      nv = put_bit(m_bank[a], b, code == 3'd5);
      m_bank[a] = nv;
      chk("R6 busy drops", busy, 0);
      chk("R6 strobe", io_wr_en, 1);
      chk("R6 write addr", io_wr_addr, a);
      chk("R6 write data", io_wr_data, nv);
      chk("R7 sreg unchanged by io op and busy-cycle op", sreg_out, m_sreg);
      chk("R7 reg_out unchanged during busy", reg_out, m_reg);
    end else begin
      chk({tag, " status byte"}, sreg_out, m_sreg);
      chk({tag, " register result"}, reg_out, m_reg);
      chk({tag, " no strobe"}, io_wr_en, 0);
      chk({tag, " not busy"}, busy, 0);
    end
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_bank[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sreg reset", sreg_out, 0);
    chk("R1 reg_out reset", reg_out, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 strobe reset", io_wr_en, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R8 idle keeps sreg", sreg_out, 0);

    do_op(3'd1, 3'd7, 8'h00, 5'd0);
    chk("R2 interrupt enable on", sreg_out[7], 1);
    do_op(3'd1, 3'd0, 8'h00, 5'd0);
    chk("R2 carry set", sreg_out, 8'h81);
    do_op(3'd2, 3'd7, 8'h00, 5'd0);
    chk("R3 interrupt enable off", sreg_out, 8'h01);
    do_op(3'd3, 3'd5, 8'h20, 5'd0);
    chk("R4 T from bit 5", sreg_out, 8'h41);
    do_op(3'd4, 3'd0, 8'hF0, 5'd0);
    chk("R5 T into bit 0", reg_out, 8'hF1);
    do_op(3'd3, 3'd0, 8'hFE, 5'd0);
    do_op(3'd4, 3'd7, 8'hFF, 5'd0);
    chk("R5 cleared T into bit 7", reg_out, 8'h7F);
    do_op(3'd0, 3'd3, 8'h55, 5'd3);
    do_op(3'd7, 3'd3, 8'h55, 5'd3);
    do_op(3'd5, 3'd7, 8'h00, 5'd31);
    do_op(3'd5, 3'd0, 8'h00, 5'd31);
    chk("R6 accumulate at top address", io_wr_data, 8'h81);
    do_op(3'd6, 3'd7, 8'h00, 5'd31);
    chk("R6 clear keeps other bit", io_wr_data, 8'h01);

    for (int n = 0; n < 600; n++) begin
      do_op(3'($urandom), 3'($urandom), 8'($urandom), 5'($urandom_range(0, 3)));
      if (($urandom & 3) == 0) begin
        @(negedge clk); op_valid = 1'b0;
        @(posedge clk); #1;
        chk("R8 idle cycle", sreg_out, m_sreg);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule